// File: doc/BRIEF.md
# Vectored Interrupt Controller with Normal and Fast Outputs

This block gathers 96 level-sensitive interrupt lines into three 32-bit banks. Source n lives in bank n/32 at bit n%32. Each line's level is sampled into a pending word once per clock. A per-source mask suppresses a line. A per-source route bit sends an unmasked pending line to the fast output (`fiq_o`) as well as to the normal output (`irq_o`). A vector value gives a byte offset equal to four times the index of the lowest-numbered pending, unmasked source. The vector is zero when no such source exists. Software reads the vector and can use it to index a table of handler addresses.

Software reaches every register through a plain word-wide port (address, write enable, write data, combinational read data) that spans a 0x400-byte window. A base-address word, a protect word and an NMI control word are stored and read back with no further effect. A per-source enable word is also stored and read back only; it gates nothing. A sticky fast-pending word records each source that has driven the fast output. Software clears it by writing ones to the bits to clear.

Top module: `irq_vector_ctrl`

## Requirements
- R1: On each rising clock edge with `rst_n` high, the pending word of bank b captures `src_lvl[32*b+31:32*b]`. Pending words read at 0x100, 0x104 and 0x108 for banks 0, 1 and 2.
- R2: `irq_o` is high exactly when some source is pending and its mask bit is 0. Mask words are at 0x140, 0x144 and 0x148, and a mask bit of 1 suppresses its source.
- R3: `fiq_o` is high exactly when some source is pending, unmasked and has its route bit set to 1. Route words are at 0x120, 0x124 and 0x128.
- R4: The vector word at 0x000 reads 4*n, where n is the lowest-numbered source that is pending and unmasked. It reads 0 when there is no such source. A write to 0x000 has no effect.
- R5: Writes to the pending words are ignored.
- R6: Fast-pending bit n (words at 0x110, 0x114 and 0x118) is set on the edge where the route bit is 1, the mask bit is 0 and the line is high. A write clears each bit that is written as 1, and setting wins over clearing on the same edge.
- R7: A write to the base-address word at 0x004 stores the data with bits [1:0] forced to 0.
- R8: Enable words at 0x130, 0x134 and 0x138 read back the last value written and have no effect on `irq_o`, `fiq_o` or the vector.
- R9: Reads from any other offset return 0, and writes to them change no register. This includes word index 3 of any group (for example 0x14C) and unaligned addresses.
- R10: Synchronous reset (`rst_n` low at a clock edge) clears every register. Both outputs are then 0.
- R11: The protect word at 0x008 and the NMI control word at 0x00C read back the full 32-bit value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lvl | input | 96 | Interrupt source levels, bit n is source n |
| reg_addr | input | 10 | Byte address of the register access |
| reg_we | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A change on `src_lvl` reaches the pending words, the fast-pending words, both outputs and the vector after exactly one rising edge. A register write shows its effect on the edge that samples the strobe. Read data follows `reg_addr` within the same cycle. The bench therefore drives every stimulus on a falling edge and compares on the next falling edge, after the single intervening rising edge. A read is sampled one time step after the address settles.

// File: rtl/vic_pkg.sv
// Package: shared constants and types for the vectored interrupt controller.
// Assumes word-wide registers and groups placed on 16-byte boundaries, so at
// most four banks fit in one group.
package vic_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 10;

    // Scalar register offsets
    localparam logic [ADDR_W-1:0] OFS_VEC  = 10'h000;
    localparam logic [ADDR_W-1:0] OFS_BASE = 10'h004;
    localparam logic [ADDR_W-1:0] OFS_PROT = 10'h008;
    localparam logic [ADDR_W-1:0] OFS_NMI  = 10'h00C;

    // Banked group bases, word index taken from address bits [3:2]
    localparam logic [ADDR_W-1:0] GRP_PEND  = 10'h100;
    localparam logic [ADDR_W-1:0] GRP_FPEND = 10'h110;
    localparam logic [ADDR_W-1:0] GRP_ROUTE = 10'h120;
    localparam logic [ADDR_W-1:0] GRP_ENA   = 10'h130;
    localparam logic [ADDR_W-1:0] GRP_MASK  = 10'h140;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_VEC,
        SEL_BASE,
        SEL_PROT,
        SEL_NMI,
        SEL_PEND,
        SEL_FPEND,
        SEL_ROUTE,
        SEL_ENA,
        SEL_MASK
    } reg_sel_e;

endpackage

// File: rtl/vic_decode.sv
// Module: address decoder for the register window.
// Maps a byte address to a register selector and a bank index. Addresses that
// are unaligned, outside every group, or name a bank past NUM_BANKS decode to
// SEL_NONE. Assumes NUM_BANKS <= 4.
module vic_decode
    import vic_pkg::*;
#(
    parameter int NUM_BANKS = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [1:0]        idx
);

    localparam int HI_W = ADDR_W - 4;
    localparam logic [HI_W-1:0] H_PEND  = GRP_PEND[ADDR_W-1:4];
    localparam logic [HI_W-1:0] H_FPEND = GRP_FPEND[ADDR_W-1:4];
    localparam logic [HI_W-1:0] H_ROUTE = GRP_ROUTE[ADDR_W-1:4];
    localparam logic [HI_W-1:0] H_ENA   = GRP_ENA[ADDR_W-1:4];
    localparam logic [HI_W-1:0] H_MASK  = GRP_MASK[ADDR_W-1:4];

    // Purpose: classify the address into one register selector.
    always_comb begin
        sel = SEL_NONE;
        idx = addr[3:2];
        if (addr[1:0] == 2'b00) begin
            if (addr == OFS_VEC)       sel = SEL_VEC;
            else if (addr == OFS_BASE) sel = SEL_BASE;
            else if (addr == OFS_PROT) sel = SEL_PROT;
            else if (addr == OFS_NMI)  sel = SEL_NMI;
            else if (int'(addr[3:2]) < NUM_BANKS) begin
                case (addr[ADDR_W-1:4])
                    H_PEND:  sel = SEL_PEND;
                    H_FPEND: sel = SEL_FPEND;
                    H_ROUTE: sel = SEL_ROUTE;
                    H_ENA:   sel = SEL_ENA;
                    H_MASK:  sel = SEL_MASK;
                    default: sel = SEL_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/vic_regs.sv
// Module: register state of the controller.
// Holds the sampled pending words, the sticky fast-pending words, and the
// route, enable and mask words, plus the base, protect and NMI words. Pending
// follows the source levels one edge later and ignores writes. Fast-pending is
// set from routed, unmasked, high lines and cleared by write-one-to-clear.
// Assumes sel/idx come from vic_decode.
module vic_regs
    import vic_pkg::*;
#(
    parameter int NUM_BANKS = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_BANKS*WORD_W-1:0]        src_lvl,
    input  logic                               we,
    input  reg_sel_e                           sel,
    input  logic [1:0]                         idx,
    input  logic [WORD_W-1:0]                  wdata,
    output logic [NUM_BANKS-1:0][WORD_W-1:0]   pend,
    output logic [NUM_BANKS-1:0][WORD_W-1:0]   fpend,
    output logic [NUM_BANKS-1:0][WORD_W-1:0]   route,
    output logic [NUM_BANKS-1:0][WORD_W-1:0]   ena,
    output logic [NUM_BANKS-1:0][WORD_W-1:0]   mask,
    output logic [WORD_W-1:0]                  base,
    output logic [WORD_W-1:0]                  prot,
    output logic [WORD_W-1:0]                  nmi
);

    // Purpose: sample source levels into pending words; writes never reach here.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= src_lvl;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [WORD_W-1:0] src_w;
        logic [WORD_W-1:0] clr_w;
        logic [WORD_W-1:0] set_w;
        logic              hit;

        assign src_w = src_lvl[b*WORD_W +: WORD_W];
        assign hit   = we && (int'(idx) == b);
        assign clr_w = (hit && sel == SEL_FPEND) ? wdata : '0;
        assign set_w = route[b] & ~mask[b] & src_w;

        // Purpose: sticky fast-pending with write-one-to-clear, set dominant.
        always_ff @(posedge clk) begin
            if (!rst_n) fpend[b] <= '0;
            else        fpend[b] <= (fpend[b] & ~clr_w) | set_w;
        end

        // Purpose: software-written route, enable and mask words of this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                route[b] <= '0;
                ena[b]   <= '0;
                mask[b]  <= '0;
            end else if (hit) begin
                if (sel == SEL_ROUTE) route[b] <= wdata;
                if (sel == SEL_ENA)   ena[b]   <= wdata;
                if (sel == SEL_MASK)  mask[b]  <= wdata;
            end
        end

        // R6
        fpend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (|(clr_w & ~set_w)) |=> ((fpend[b] & $past(clr_w & ~set_w)) == '0));
    end

    // Purpose: scalar words; base drops its two low bits on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
            prot <= '0;
            nmi  <= '0;
        end else if (we) begin
            if (sel == SEL_BASE) base <= {wdata[WORD_W-1:2], 2'b00};
            if (sel == SEL_PROT) prot <= wdata;
            if (sel == SEL_NMI)  nmi  <= wdata;
        end
    end

    // R1
    pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pend == $past(src_lvl)));

endmodule

// File: rtl/vic_ffs.sv
// Module: find-first-set on one word.
// Returns the position of the lowest set bit and a valid flag; the position
// is 0 when the word is zero.
module vic_ffs #(
    parameter int W = 32,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  word,
    output logic [IW-1:0] pos,
    output logic          valid
);

    // Purpose: scan from the top so the lowest set bit is written last.
    always_comb begin
        pos = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (word[i]) pos = IW'(i);
        end
        valid = |word;
    end

endmodule

// File: rtl/vic_resolve.sv
// Module: output and vector resolution.
// Combines pending, mask and route into the normal and fast requests and picks
// the lowest-numbered active source as a byte-offset vector (index times 4).
// Purely combinational; assumes its inputs are registered upstream.
module vic_resolve
    import vic_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    localparam int VEC_W = $clog2(NUM_BANKS * WORD_W * 4),
    localparam int IW = $clog2(WORD_W)
) (
    input  logic [NUM_BANKS-1:0][WORD_W-1:0] pend,
    input  logic [NUM_BANKS-1:0][WORD_W-1:0] route,
    input  logic [NUM_BANKS-1:0][WORD_W-1:0] mask,
    output logic                             irq,
    output logic                             fiq,
    output logic [VEC_W-1:0]                 vec
);

    logic [NUM_BANKS-1:0][WORD_W-1:0] live;
    logic [NUM_BANKS-1:0][IW-1:0]     pos;
    logic [NUM_BANKS-1:0]             valid;
    logic [NUM_BANKS-1:0]             fast;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign live[b] = pend[b] & ~mask[b];
        assign fast[b] = |(live[b] & route[b]);

        vic_ffs #(.W(WORD_W)) u_ffs (
            .word  (live[b]),
            .pos   (pos[b]),
            .valid (valid[b])
        );
    end

    assign irq = |valid;
    assign fiq = |fast;

    // Purpose: first bank with a live source, from bank 0 upward, sets the vector.
    always_comb begin
        logic found;
        found = 1'b0;
        vec   = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (!found && valid[b]) begin
                vec   = VEC_W'((b * WORD_W + int'(pos[b])) * 4);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
// Module: top of the vectored interrupt controller.
// Decodes the register port, holds state in vic_regs, resolves outputs in
// vic_resolve and muxes read data. Read data is combinational on the address;
// writes take effect at the rising edge that samples reg_we.
module irq_vector_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    localparam int NUM_SRC = NUM_BANKS * WORD_W,
    localparam int VEC_W = $clog2(NUM_SRC * 4)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_lvl,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_we,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic                 irq_o,
    output logic                 fiq_o
);

    reg_sel_e                         sel;
    logic [1:0]                       idx;
    logic [NUM_BANKS-1:0][WORD_W-1:0] pend, fpend, route, ena, mask;
    logic [WORD_W-1:0]                base, prot, nmi;
    logic [VEC_W-1:0]                 vec;

    vic_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .addr (reg_addr),
        .sel  (sel),
        .idx  (idx)
    );

    vic_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_lvl (src_lvl),
        .we      (reg_we),
        .sel     (sel),
        .idx     (idx),
        .wdata   (reg_wdata),
        .pend    (pend),
        .fpend   (fpend),
        .route   (route),
        .ena     (ena),
        .mask    (mask),
        .base    (base),
        .prot    (prot),
        .nmi     (nmi)
    );

    vic_resolve #(.NUM_BANKS(NUM_BANKS)) u_res (
        .pend  (pend),
        .route (route),
        .mask  (mask),
        .irq   (irq_o),
        .fiq   (fiq_o),
        .vec   (vec)
    );

    // Purpose: select read data; undefined offsets read zero.
    always_comb begin
        case (sel)
            SEL_VEC:   reg_rdata = WORD_W'(vec);
            SEL_BASE:  reg_rdata = base;
            SEL_PROT:  reg_rdata = prot;
            SEL_NMI:   reg_rdata = nmi;
            SEL_PEND:  reg_rdata = pend[idx];
            SEL_FPEND: reg_rdata = fpend[idx];
            SEL_ROUTE: reg_rdata = route[idx];
            SEL_ENA:   reg_rdata = ena[idx];
            SEL_MASK:  reg_rdata = mask[idx];
            default:   reg_rdata = '0;
        endcase
    end

    // R3
    fiq_implies_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> irq_o);

    // R4
    idle_vector_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (vec == '0));

    // R7
    base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_BASE) |-> (reg_rdata[1:0] == 2'b00));

    // R10
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!irq_o && !fiq_o));

endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;

    localparam int NB = 3;
    localparam int NS = NB * 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NS-1:0]     src_lvl = '0;
    logic [9:0]        reg_addr = '0;
    logic              reg_we = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              irq_o, fiq_o;

    int n_tests = 0;
    int n_fail  = 0;

    irq_vector_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_lvl   (src_lvl),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic drive(input logic [NS-1:0] v);
        @(negedge clk);
        src_lvl = v;
        @(negedge clk);
    endtask

    function automatic logic [31:0] exp_vec(input logic [NS-1:0] s, input logic [NS-1:0] m);
        for (int i = 0; i < NS; i++) if (s[i] && !m[i]) return 32'(i * 4);
        return 32'd0;
    endfunction

    initial begin
        #(200000 * 10);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [NS-1:0] s, m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: every defined register reads zero after reset
        for (int a = 0; a < 16; a += 4) begin
            rd(10'(a), d); chk("R10 scalar", d, 0);
        end
        for (int g = 0; g < 5; g++) for (int b = 0; b < NB; b++) begin
            rd(10'('h100 + g * 16 + b * 4), d); chk("R10 bank", d, 0);
        end
        chk("R10 irq", 32'(irq_o), 0);
        chk("R10 fiq", 32'(fiq_o), 0);

        // R7 / R11: base alignment, protect and NMI storage
        wr(10'h004, 32'hFFFF_FFFF); rd(10'h004, d); chk("R7 base", d, 32'hFFFF_FFFC);
        wr(10'h004, 32'h1234_5677); rd(10'h004, d); chk("R7 base", d, 32'h1234_5674);
        wr(10'h008, 32'hDEAD_BEEF); rd(10'h008, d); chk("R11 protect", d, 32'hDEAD_BEEF);
        wr(10'h00C, 32'h0000_0003); rd(10'h00C, d); chk("R11 nmi", d, 32'h3);

        // R1 R2 R4: single-source sweep over all sources
        for (int n = 0; n < NS; n++) begin
            s = '0; s[n] = 1'b1;
            drive(s);
            chk("R2 irq single", 32'(irq_o), 1);
            chk("R3 fiq unrouted", 32'(fiq_o), 0);
            rd(10'('h100 + (n / 32) * 4), d); chk("R1 pending word", d, 32'h1 << (n % 32));
            rd(10'h000, d); chk("R4 vector single", d, 32'(n * 4));
        end
        drive('0);
        chk("R2 irq idle", 32'(irq_o), 0);
        rd(10'h000, d); chk("R4 vector idle", d, 0);

        // R3 R6: routing to the fast output and sticky fast-pending
        wr(10'h124, 32'h0000_0100);          // source 40 routed
        s = '0; s[40] = 1'b1; drive(s);
        chk("R3 fiq routed", 32'(fiq_o), 1);
        rd(10'h114, d); chk("R6 fpend set", d, 32'h100);
        s = '0; s[41] = 1'b1; drive(s);
        chk("R3 fiq other source", 32'(fiq_o), 0);
        chk("R2 irq other source", 32'(irq_o), 1);
        rd(10'h114, d); chk("R6 fpend sticky", d, 32'h100);
        wr(10'h114, 32'h0000_0001); rd(10'h114, d); chk("R6 zero bits keep", d, 32'h100);
        wr(10'h114, 32'h0000_0100); rd(10'h114, d); chk("R6 w1c", d, 0);
        s = '0; s[40] = 1'b1; drive(s);
        wr(10'h114, 32'h0000_0100); rd(10'h114, d); chk("R6 set wins", d, 32'h100);
        drive('0);
        wr(10'h114, 32'hFFFF_FFFF); wr(10'h124, 32'h0);

        // R2 R3 R4: priority across banks with masking
        s = '0; s[3] = 1'b1; s[50] = 1'b1; s[90] = 1'b1;
        drive(s);
        m = '0;
        rd(10'h000, d); chk("R4 priority", d, exp_vec(s, m));
        wr(10'h140, 32'h0000_0008); m[3] = 1'b1;
        rd(10'h000, d); chk("R4 mask bank0", d, exp_vec(s, m));
        wr(10'h144, 32'hFFFF_FFFF); m[63:32] = '1;
        rd(10'h000, d); chk("R4 mask bank1", d, exp_vec(s, m));
        wr(10'h128, 32'h0400_0000);          // route source 90
        chk("R3 fiq routed bank2", 32'(fiq_o), 1);
        wr(10'h148, 32'h0400_0000); m[90] = 1'b1;
        chk("R2 irq all masked", 32'(irq_o), 0);
        chk("R3 fiq masked", 32'(fiq_o), 0);
        rd(10'h000, d); chk("R4 vector masked", d, 0);

        // R9: undefined offsets read zero and change nothing
        wr(10'h14C, 32'hFFFF_FFFF);
        rd(10'h14C, d); chk("R9 read idx3", d, 0);
        rd(10'h140, d); chk("R9 mask0 kept", d, 32'h8);
        wr(10'h3FC, 32'hFFFF_FFFF); rd(10'h3FC, d); chk("R9 read top", d, 0);
        wr(10'h006, 32'h0);  rd(10'h004, d); chk("R9 unaligned no effect", d, 32'h1234_5674);
        wr(10'h148, 32'h0); wr(10'h144, 32'h0); wr(10'h140, 32'h0);
        wr(10'h000, 32'h0000_0044); rd(10'h000, d); chk("R4 vector write ignored", d, 32'd12);

        // R8: enable stored only, no gating
        wr(10'h130, 32'hA5A5_0000); rd(10'h130, d); chk("R8 enable readback", d, 32'hA5A5_0000);
        chk("R8 irq ungated", 32'(irq_o), 1);
        rd(10'h000, d); chk("R8 vector ungated", d, 32'd12);

        // R5: pending ignores writes
        drive('0);
        wr(10'h100, 32'hFFFF_FFFF); wr(10'h108, 32'hFFFF_FFFF);
        rd(10'h100, d); chk("R5 pending0", d, 0);
        rd(10'h108, d); chk("R5 pending2", d, 0);
        chk("R5 irq", 32'(irq_o), 0);

        // R10: reset clears stored words again
        s = '0; s[7] = 1'b1; drive(s);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; src_lvl = '0;
        rd(10'h004, d); chk("R10 base cleared", d, 0);
        rd(10'h130, d); chk("R10 enable cleared", d, 0);
        rd(10'h128, d); chk("R10 route cleared", d, 0);
        chk("R10 irq after reset", 32'(irq_o), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule